// File: doc/BRIEF.md
# Add-Compare-Select Cell with Wrap-Around Metrics

This cell is the decision step of one state in a two-state trellis decoder. It receives the accumulated path costs of the two predecessor states and the two branch costs that lead into its own state. It adds each branch cost to its predecessor cost, keeps the cheaper of the two candidates as the new path cost, and reports which predecessor survived so that a trace-back unit can follow the path later. A full trellis stage uses two copies of the cell. Both copies read the same pair of old path costs, and each has its own pair of branch costs.

The cell is purely combinational. It has no clock, no registers and no reset. Path costs are never rescaled. They are allowed to wrap modulo 2^METRIC_W, and the comparison is made on the top bit of the wrapped difference of the two candidates. This ordering stays correct as long as the true distance between the candidates is below half the metric range. With the default 8-bit metrics and 5-bit branch costs, a two-state trellis keeps that distance far below the limit.

Top module: `acs_cell`

## Requirements
- R1: Each candidate is the old path cost plus the zero-extended unsigned branch cost, taken modulo 2^METRIC_W. Any carry out of the top bit is dropped (255 + 31 gives 30 with the defaults).
- R2: The decision output `pick_b_o` is 1 when the top bit of (candidate A − candidate B) mod 2^METRIC_W is 0. It is 0 when that bit is 1.
- R3: `metric_o` equals candidate A when `pick_b_o` is 0 and candidate B when `pick_b_o` is 1.
- R4: When the two candidates are equal, path B is chosen: `pick_b_o` is 1 and `metric_o` equals candidate B.
- R5: When the true (unwrapped) distance between the candidates is below 2^(METRIC_W−1), `metric_o` equals the true minimum modulo 2^METRIC_W, including when either candidate has wrapped past the top of the range.
- R6: The outputs follow the inputs with no clock edge. A change at the inputs shows at `metric_o` and `pick_b_o` in the same cycle.
- R7: Branch costs are unsigned. Their top bit carries weight 2^(BRANCH_W−1) and is never treated as a sign.
- R8: At a wrapped distance of exactly 2^(METRIC_W−1), path A is chosen whichever candidate is truly smaller. At a distance of 2^(METRIC_W−1)−1, the truly smaller candidate is chosen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| metric_a_i | input | METRIC_W | Old path cost of predecessor A |
| metric_b_i | input | METRIC_W | Old path cost of predecessor B |
| branch_a_i | input | BRANCH_W | Unsigned branch cost from A into this state |
| branch_b_i | input | BRANCH_W | Unsigned branch cost from B into this state |
| metric_o | output | METRIC_W | New path cost of this state (wrapped) |
| pick_b_o | output | 1 | Survivor decision: 0 = path A, 1 = path B |

## Verification
Both results are due in the same cycle the inputs settle, because no register lies between ports. The bench therefore applies each stimulus on the falling clock edge and compares one nanosecond later, well before the next rising edge. In the trellis run, two cells feed bench-held path-cost registers. The new costs are compared before the rising edge that loads them, so any error shows up in the cycle it is made. They are checked against a wide-integer model that subtracts the common minimum from time to time and compares modulo 256.

// File: rtl/acs_pkg.sv
package acs_pkg;
    // Default widths for the add-compare-select datapath.
    localparam int unsigned ACS_METRIC_W = 8;
    localparam int unsigned ACS_BRANCH_W = 5;
endpackage

// File: rtl/acs_add.sv
module acs_add #(
    parameter int unsigned METRIC_W = acs_pkg::ACS_METRIC_W,
    parameter int unsigned BRANCH_W = acs_pkg::ACS_BRANCH_W
) (
    input  logic [METRIC_W-1:0] metric_i,
    input  logic [BRANCH_W-1:0] branch_i,
    output logic [METRIC_W-1:0] cand_o
);
    localparam int unsigned PAD_W = METRIC_W - BRANCH_W;

    typedef struct packed {
        logic [METRIC_W-1:0] cand;
    } add_res_t;

    add_res_t res_d;

    always_comb begin
        // Unsigned branch cost, zero extended; carry out of the top bit dropped.
        res_d.cand = metric_i + {{PAD_W{1'b0}}, branch_i};
    end

    assign cand_o = res_d.cand;

    always_comb begin
        if (!$isunknown({metric_i, branch_i, cand_o})) begin
            if (branch_i == '0)
                assert_zero_branch_keeps_metric_R1: assert (cand_o == metric_i)
                    else $error("R1: zero branch cost altered the metric");
        end
    end
endmodule

// File: rtl/acs_cmp.sv
module acs_cmp #(
    parameter int unsigned METRIC_W = acs_pkg::ACS_METRIC_W
) (
    input  logic [METRIC_W-1:0] cand_a_i,
    input  logic [METRIC_W-1:0] cand_b_i,
    output logic                pick_b_o
);
    localparam int unsigned TOP = METRIC_W - 1;

    typedef struct packed {
        logic [METRIC_W-1:0] diff;
        logic                pick_b;
    } cmp_res_t;

    cmp_res_t res_d;

    always_comb begin
        // Wrapped difference; its top bit tells which candidate is ahead.
        res_d.diff   = cand_a_i - cand_b_i;
        res_d.pick_b = ~res_d.diff[TOP];
    end

    assign pick_b_o = res_d.pick_b;

    always_comb begin
        if (!$isunknown({cand_a_i, cand_b_i, pick_b_o})) begin
            if (res_d.diff == '0)
                assert_tie_goes_to_b_R4: assert (pick_b_o == 1'b1)
                    else $error("R4: tie did not select path B");
        end
    end
endmodule

// File: rtl/acs_sel.sv
module acs_sel #(
    parameter int unsigned METRIC_W = acs_pkg::ACS_METRIC_W
) (
    input  logic [METRIC_W-1:0] cand_a_i,
    input  logic [METRIC_W-1:0] cand_b_i,
    input  logic                pick_b_i,
    output logic [METRIC_W-1:0] metric_o
);
    // One 2:1 multiplexer per metric bit.
    for (genvar gi = 0; gi < METRIC_W; gi++) begin : g_bit
        logic bit_d;
        always_comb begin
            bit_d = pick_b_i ? cand_b_i[gi] : cand_a_i[gi];
        end
        assign metric_o[gi] = bit_d;
    end

    always_comb begin
        if (!$isunknown({cand_a_i, cand_b_i, pick_b_i, metric_o})) begin
            assert_out_is_a_candidate_R3: assert ((metric_o == cand_a_i) || (metric_o == cand_b_i))
                else $error("R3: output matches neither candidate");
        end
    end
endmodule

// File: rtl/acs_cell.sv
module acs_cell #(
    parameter int unsigned METRIC_W = acs_pkg::ACS_METRIC_W,
    parameter int unsigned BRANCH_W = acs_pkg::ACS_BRANCH_W
) (
    input  logic [METRIC_W-1:0] metric_a_i,
    input  logic [METRIC_W-1:0] metric_b_i,
    input  logic [BRANCH_W-1:0] branch_a_i,
    input  logic [BRANCH_W-1:0] branch_b_i,
    output logic [METRIC_W-1:0] metric_o,
    output logic                pick_b_o
);
    localparam int unsigned TOP = METRIC_W - 1;

    logic [METRIC_W-1:0] cand_a;
    logic [METRIC_W-1:0] cand_b;
    logic                pick_b;

    acs_add #(.METRIC_W(METRIC_W), .BRANCH_W(BRANCH_W)) u_add_a (
        .metric_i (metric_a_i),
        .branch_i (branch_a_i),
        .cand_o   (cand_a)
    );

    acs_add #(.METRIC_W(METRIC_W), .BRANCH_W(BRANCH_W)) u_add_b (
        .metric_i (metric_b_i),
        .branch_i (branch_b_i),
        .cand_o   (cand_b)
    );

    acs_cmp #(.METRIC_W(METRIC_W)) u_cmp (
        .cand_a_i (cand_a),
        .cand_b_i (cand_b),
        .pick_b_o (pick_b)
    );

    acs_sel #(.METRIC_W(METRIC_W)) u_sel (
        .cand_a_i (cand_a),
        .cand_b_i (cand_b),
        .pick_b_i (pick_b),
        .metric_o (metric_o)
    );

    assign pick_b_o = pick_b;

    // The survivor never sits above the loser in wrapped order.
    logic [METRIC_W-1:0] loser_gap;
    always_comb begin
        loser_gap = metric_o - (pick_b ? cand_a : cand_b);
        if (!$isunknown({cand_a, cand_b, pick_b, metric_o})) begin
            assert_winner_not_above_R5: assert (loser_gap[TOP] || (loser_gap == '0))
                else $error("R5: survivor ranks above the discarded path");
        end
    end
endmodule

// File: tb/tb_acs_cell.sv
module tb_acs_cell;
    localparam int MW = 8;
    localparam int BW = 5;
    localparam int TRELLIS_STEPS = 4000;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [MW-1:0] s1, s2;
    logic [BW-1:0] b_aa, b_ba, b_ab, b_bb;
    logic [MW-1:0] nsm1, nsm2;
    logic          dec1, dec2;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    acs_cell #(.METRIC_W(MW), .BRANCH_W(BW)) dut (
        .metric_a_i (s1), .metric_b_i (s2),
        .branch_a_i (b_aa), .branch_b_i (b_ba),
        .metric_o (nsm1), .pick_b_o (dec1)
    );

    acs_cell #(.METRIC_W(MW), .BRANCH_W(BW)) u_acs2 (
        .metric_a_i (s1), .metric_b_i (s2),
        .branch_a_i (b_ab), .branch_b_i (b_bb),
        .metric_o (nsm2), .pick_b_o (dec2)
    );

    task automatic chk(input string tag, input int act, input int exp_v);
        n_cmp++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    task automatic directed(input string tag, input int a, input int ba,
                            input int b, input int bb, input int exp_m, input int exp_d);
        @(negedge clk);
        s1 = MW'(a); b_aa = BW'(ba); s2 = MW'(b); b_ba = BW'(bb);
        #1;
        chk({tag, " metric"}, int'(nsm1), exp_m);
        chk({tag, " decision"}, int'(dec1), exp_d);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        longint g1, g2, base, c1, c2, c3, c4, n1, n2;
        int e_d1, e_d2;
        s1 = '0; s2 = '0; b_aa = '0; b_ba = '0; b_ab = '0; b_bb = '0;
        repeat (2) @(posedge clk);

        // Idle/all-zero state: tie at zero selects path B (R4).
        directed("R4 zeros", 0, 0, 0, 0, 0, 1);
        // Plain selection of the smaller candidate A (R3).
        directed("R3 pick A", 10, 5, 20, 3, 15, 0);
        directed("R3 pick B", 40, 9, 30, 2, 32, 1);
        // Candidate A wraps past 255: true 260 vs 242 -> 242 (R5).
        directed("R5 wrapped A", 250, 10, 240, 2, 242, 1);
        // Candidate B wraps: true 250 vs 262 -> 250 (R5).
        directed("R5 wrapped B", 245, 5, 251, 11, 250, 0);
        // Carry dropped: 255+31 = 30 both sides, tie -> B (R1, R4).
        directed("R1 carry drop", 255, 31, 255, 31, 30, 1);
        directed("R1 carry drop A", 255, 31, 100, 0, 30, 0);
        // Distance 127 either way: true minimum chosen (R8).
        directed("R8 gap 127 B", 200, 0, 73, 0, 73, 1);
        directed("R8 gap 127 A", 73, 0, 200, 0, 73, 0);
        // Distance 128: path A chosen regardless (R8).
        directed("R8 gap 128 A", 128, 0, 0, 0, 128, 0);
        directed("R8 gap 128 B", 0, 0, 128, 0, 0, 0);
        // Top branch bit has weight 16, unsigned (R7).
        directed("R7 unsigned", 0, 16, 17, 0, 16, 0);
        directed("R7 unsigned max", 0, 31, 30, 0, 30, 1);
        // R6: inputs changed between edges, outputs follow within 1 ns.
        @(negedge clk);
        s1 = 8'd5; b_aa = 5'd1; s2 = 8'd9; b_ba = 5'd0;
        #1 chk("R6 settle first", int'(nsm1), 6);
        s2 = 8'd2;
        #0.5 chk("R6 settle second", int'(nsm1), 2);
        chk("R6 settle decision", int'(dec1), 1);

        // Two-state trellis with bench-held metric registers (R2, R5).
        g1 = 0; g2 = 0; base = 0;
        @(negedge clk);
        s1 = '0; s2 = '0;
        for (int step = 0; step < TRELLIS_STEPS; step++) begin
            b_aa = BW'($urandom_range(0, 31));
            b_ba = BW'($urandom_range(0, 31));
            b_ab = BW'($urandom_range(0, 31));
            b_bb = BW'($urandom_range(0, 31));
            c1 = g1 + longint'(b_aa); c2 = g2 + longint'(b_ba);
            c3 = g1 + longint'(b_ab); c4 = g2 + longint'(b_bb);
            if (c2 <= c1) begin n1 = c2; e_d1 = 1; end else begin n1 = c1; e_d1 = 0; end
            if (c4 <= c3) begin n2 = c4; e_d2 = 1; end else begin n2 = c3; e_d2 = 0; end
            #1;
            chk("R5 trellis state1 metric", int'(nsm1), int'((n1 + base) % 256));
            chk("R2 trellis state1 decision", int'(dec1), e_d1);
            chk("R5 trellis state2 metric", int'(nsm2), int'((n2 + base) % 256));
            chk("R2 trellis state2 decision", int'(dec2), e_d2);
            g1 = n1; g2 = n2;
            if ((step % 16) == 15) begin
                longint m;
                m = (g1 < g2) ? g1 : g2;
                g1 -= m; g2 -= m; base += m;
            end
            @(posedge clk);
            s1 = nsm1; s2 = nsm2;
            @(negedge clk);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule